// File: doc/BRIEF.md
# Rectangular Block Transfer Address Sequencer

This block steps through a rectangle of 16-bit words held in a byte-addressed memory. It drives up to four channels: three sources (A, B, C) that read and one destination (D) that writes. Software loads a pointer and a row modulo for each channel, a control word and a size word. The write of the size word starts the walk at once. The sequencer then moves through the rectangle one word at a time and one row at a time. For each word it issues a read for every enabled source, then a write for the destination.

The memory port is a plain request/grant pair. The sequencer holds its request steady while the grant is withheld, so contention can be modelled simply by holding the grant low. The data-combining function sits outside this block. In its place a small stand-in forwards one source word to the destination write. The block also marks the first and last word of each row, so that edge masking can be added later.

Top module: `blit_seq`

## Requirements
- R1: Size word (select 1): bits 15:6 hold the row count and bits 5:0 the words per row. A row field of 0 means 1024 rows, and a width field of 0 means 64 words.
- R2: A write to select 1 while idle raises `busy_o` from the next cycle. `busy_o` falls on the edge that accepts the final granted access. Reset leaves `busy_o` and `mem_req_o` low.
- R3: Control word (select 0) bits 11:8 enable channels A, B, C and D in that order. A disabled channel never requests. With the grant held high, one word takes as many cycles as there are enabled channels.
- R4: For each word, the accesses go in the order A, B, C, D, skipping disabled channels. `mem_ch_o` carries codes 0 to 3 for A to D, and `mem_we_o` is high only for D.
- R5: Ascending mode (control bit 1 = 0): each channel's address starts at its pointer (select 4+ch) and rises by 2 after each word. After the last word of a row, it also adds that channel's signed 16-bit modulo (select 8+ch).
- R6: Descending mode (control bit 1 = 1): the address falls by 2 after each word. After the last word of a row, the modulo is also subtracted.
- R7: Pointers keep their advanced values after a walk ends. A later start with no pointer writes continues from where the previous walk stopped.
- R8: While `mem_req_o` is high and `mem_gnt_i` is low, the request, channel, address and write flag hold their values.
- R9: `mem_first_o` is high on every access to the first word of a row, and `mem_last_o` is high on every access to the last word of a row.
- R10: Register writes of any select are ignored while `busy_o` is high, including writes to the size word.
- R11: The destination write data equals the A word read for the same word position if A is enabled, otherwise B, otherwise C, otherwise zero.
- R12: A size write while no channel is enabled starts nothing, and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 4 | Register select: 0 control, 1 size, 4-7 pointers, 8-11 modulos |
| reg_wdata_i | input | REG_W | Register write data |
| busy_o | output | 1 | A walk is in progress |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a destination write |
| mem_ch_o | output | 2 | Channel of the current access |
| mem_addr_o | output | ADDR_W | Byte address of the current access |
| mem_first_o | output | 1 | Access belongs to the first word of a row |
| mem_last_o | output | 1 | Access belongs to the last word of a row |
| mem_wdata_o | output | DATA_W | Destination write data |
| mem_rdata_i | input | DATA_W | Read data, valid in the granted cycle |
| mem_gnt_i | input | 1 | Grant; the access completes on the edge where it is high |

## Verification
The bench aims at the zero-field encodings of the size word: a sequencer that took 0 literally would finish at once, or after one row or word, instead of walking 1024 rows or 64 words. Modulo handling is checked with signed, non-zero modulos in both directions. A sequencer that added the modulo on every word, or added it while descending, issues wrong addresses from the second row on. Random grant gaps expose any request that moves during a stall, and back-to-back walks without pointer writes expose pointers that are restored. Register writes injected in the middle of a walk, including a second size write, show whether the walk is corrupted or restarted.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int NCH = 4;
  localparam int W_FIELD = 6;
  localparam int H_FIELD = 10;
  localparam int W_CW = W_FIELD + 1;
  localparam int H_CW = H_FIELD + 1;

  localparam logic [3:0] SEL_CTRL = 4'd0;
  localparam logic [3:0] SEL_SIZE = 4'd1;
  localparam logic [1:0] SEL_PTR  = 2'b01;  // selects 4..7
  localparam logic [1:0] SEL_MOD  = 2'b10;  // selects 8..11
  localparam logic [1:0] CH_DST   = 2'd3;

  function automatic logic [1:0] lowest_en(input logic [3:0] en);
    logic [1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) if (en[i]) r = i[1:0];
    return r;
  endfunction

  // {found, index} of the lowest enabled channel above cur
  function automatic logic [2:0] next_en(input logic [3:0] en, input logic [1:0] cur);
    logic [2:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (en[i] && (i > int'(cur))) r = {1'b1, i[1:0]};
    return r;
  endfunction
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int REG_W  = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [3:0]                 sel_i,
  input  logic [REG_W-1:0]           wdata_i,
  input  logic                       busy_i,
  input  logic                       step_i,
  input  logic [1:0]                 step_ch_i,
  input  logic                       row_end_i,
  output logic [3:0]                 en_o,
  output logic                       desc_o,
  output logic                       start_o,
  output logic [W_CW-1:0]            width_o,
  output logic [H_CW-1:0]            height_o,
  output logic [NCH-1:0][ADDR_W-1:0] ptr_o
);
  localparam int EXT = ADDR_W - 16;
  localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(2);

  logic wr_ok;
  logic [W_FIELD-1:0] w_fld;
  logic [H_FIELD-1:0] h_fld;
  logic [NCH-1:0][15:0] mod_q;
  logic unused_wdata;

  assign wr_ok = we_i && !busy_i;
  assign w_fld = wdata_i[W_FIELD-1:0];
  assign h_fld = wdata_i[W_FIELD+H_FIELD-1:W_FIELD];
  assign width_o  = (w_fld == '0) ? W_CW'(64)   : {1'b0, w_fld};
  assign height_o = (h_fld == '0) ? H_CW'(1024) : {1'b0, h_fld};
  assign start_o  = wr_ok && (sel_i == SEL_SIZE) && (en_o != '0);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      desc_o <= 1'b0;
    end else if (wr_ok && sel_i == SEL_CTRL) begin
      en_o   <= wdata_i[11:8];
      desc_o <= wdata_i[1];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [ADDR_W-1:0] delta;
    assign delta = row_end_i ? WSTEP + {{EXT{mod_q[g][15]}}, mod_q[g]} : WSTEP;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_o[g] <= '0;
        mod_q[g] <= '0;
      end else begin
        if (wr_ok && sel_i == {SEL_PTR, 2'(g)})
          ptr_o[g] <= wdata_i[ADDR_W-1:0];
        else if (step_i && step_ch_i == 2'(g))
          ptr_o[g] <= desc_o ? ptr_o[g] - delta : ptr_o[g] + delta;
        if (wr_ok && sel_i == {SEL_MOD, 2'(g)})
          mod_q[g] <= wdata_i[15:0];
      end
    end
  end
endmodule

// File: rtl/blit_walk.sv
module blit_walk
  import blit_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [3:0]      en_i,
  input  logic [W_CW-1:0] width_i,
  input  logic [H_CW-1:0] height_i,
  input  logic            gnt_i,
  output logic            busy_o,
  output logic [1:0]      ch_o,
  output logic            first_o,
  output logic            last_o,
  output logic            step_o
);
  logic [W_CW-1:0] col_q, w_q;
  logic [H_CW-1:0] row_q, h_q;
  logic [2:0]      nxt;

  assign nxt     = next_en(en_i, ch_o);
  assign step_o  = busy_o && gnt_i;
  assign first_o = (col_q == '0);
  assign last_o  = (col_q == w_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      ch_o   <= '0;
      col_q  <= '0;
      row_q  <= '0;
      w_q    <= W_CW'(1);
      h_q    <= H_CW'(1);
    end else if (start_i) begin
      busy_o <= 1'b1;
      ch_o   <= lowest_en(en_i);
      col_q  <= '0;
      row_q  <= '0;
      w_q    <= width_i;
      h_q    <= height_i;
    end else if (step_o) begin
      if (nxt[2]) begin
        ch_o <= nxt[1:0];
      end else begin
        ch_o <= lowest_en(en_i);
        if (last_o) begin
          col_q <= '0;
          if (row_q == h_q - 1'b1) busy_o <= 1'b0;
          else row_q <= row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/blit_pass.sv
module blit_pass
  import blit_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [1:0]        ch_i,
  input  logic [3:0]        en_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] wdata_o
);
  logic [NCH-2:0][DATA_W-1:0] hold_q;

  for (genvar g = 0; g < NCH - 1; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hold_q[g] <= '0;
      else if (step_i && ch_i == 2'(g)) hold_q[g] <= rdata_i;
    end
  end

  always_comb begin
    wdata_o = '0;
    for (int i = NCH - 2; i >= 0; i--) if (en_i[i]) wdata_o = hold_q[i];
  end
endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_ch_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_first_o,
  output logic              mem_last_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_gnt_i
);
  logic [3:0]                 ch_en;
  logic                       desc, start, step;
  logic [W_CW-1:0]            width;
  logic [H_CW-1:0]            height;
  logic [NCH-1:0][ADDR_W-1:0] ptr;

  blit_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .busy_i(busy_o), .step_i(step), .step_ch_i(mem_ch_o), .row_end_i(mem_last_o),
    .en_o(ch_en), .desc_o(desc), .start_o(start),
    .width_o(width), .height_o(height), .ptr_o(ptr)
  );

  blit_walk u_walk (
    .clk_i, .rst_ni,
    .start_i(start), .en_i(ch_en), .width_i(width), .height_i(height),
    .gnt_i(mem_gnt_i), .busy_o(busy_o), .ch_o(mem_ch_o),
    .first_o(mem_first_o), .last_o(mem_last_o), .step_o(step)
  );

  blit_pass #(.DATA_W(DATA_W)) u_pass (
    .clk_i, .rst_ni,
    .step_i(step), .ch_i(mem_ch_o), .en_i(ch_en),
    .rdata_i(mem_rdata_i), .wdata_o(mem_wdata_o)
  );

  logic unused_desc;
  assign unused_desc = desc;

  assign mem_req_o  = busy_o;
  assign mem_we_o   = busy_o && (mem_ch_o == CH_DST);
  assign mem_addr_o = ptr[mem_ch_o];
endmodule

// File: rtl/blit_seq_chk.sv
module blit_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [3:0]        reg_sel_i,
  input logic              busy_i,
  input logic              req_i,
  input logic [1:0]        ch_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              gnt_i,
  input logic [3:0]        ch_en_i
);
  p_start_by_size_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(reg_we_i && reg_sel_i == 4'd1));

  p_enabled_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> ch_en_i[ch_i]);

  p_order_in_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && gnt_i && ch_i != 2'd3 && ch_en_i[3] |=> req_i && ch_i > $past(ch_i));

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !gnt_i |=> req_i && $stable(addr_i) && $stable(ch_i));

  p_ctrl_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && reg_we_i && reg_sel_i == 4'd0 |=> $stable(ch_en_i));

  p_empty_start_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && reg_we_i && reg_sel_i == 4'd1 && ch_en_i == 4'd0 |=> !busy_i);
endmodule

bind blit_seq blit_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
  .busy_i(busy_o), .req_i(mem_req_o), .ch_i(mem_ch_o), .addr_i(mem_addr_o),
  .gnt_i(mem_gnt_i), .ch_en_i(ch_en)
);

// File: tb/tb_blit_seq.sv
`timescale 1ns/1ps
module tb_blit_seq;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic busy, req, we, first, last, gnt;
  logic [1:0] ch;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  always #2.5 clk = ~clk;

  blit_seq #(.ADDR_W(AW), .DATA_W(DW), .REG_W(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .busy_o(busy), .mem_req_o(req), .mem_we_o(we),
    .mem_ch_o(ch), .mem_addr_o(addr), .mem_first_o(first), .mem_last_o(last),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_gnt_i(gnt)
  );

  assign rdata = addr[15:0] ^ 16'h3C96;

  int checks = 0, fails = 0, gp = 100;
  logic [AW-1:0] ep [4];
  logic [15:0]   em [4];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_ptr(input int i, input logic [AW-1:0] v);
    wr(4'(4 + i), 32'(v)); ep[i] = v;
  endtask

  task automatic set_mod(input int i, input logic [15:0] v);
    wr(4'(8 + i), {16'h0, v}); em[i] = v;
  endtask

  function automatic logic [15:0] exp_w(input logic [3:0] en, input logic [15:0] s0,
                                        input logic [15:0] s1, input logic [15:0] s2);
    if (en[0]) return s0;
    if (en[1]) return s1;
    if (en[2]) return s2;
    return 16'h0;
  endfunction

  // Programs control and size, then follows every access against the model.
  task automatic run(input logic [3:0] en, input bit desc, input logic [15:0] size,
                     input bit midwrite, output int cyc);
    int w, h, nacc, tries;
    logic [15:0] sv [3];
    logic [AW-1:0] stp;
    bit ok;
    w = (size[5:0] == 0) ? 64 : int'(size[5:0]);
    h = (size[15:6] == 0) ? 1024 : int'(size[15:6]);
    nacc = 0; cyc = 0;
    sv[0] = '0; sv[1] = '0; sv[2] = '0;
    wr(4'd0, {20'h0, en, 6'h0, desc, 1'b0});
    wr(4'd1, {16'h0, size});
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        for (int k = 0; k < 4; k++) begin
          if (!en[k]) continue;
          tries = 0;
          if (midwrite) begin
            reg_we = (nacc < 3);
            case (nacc)
              0: begin reg_sel = 4'd4; reg_wdata = 32'h0; end
              1: begin reg_sel = 4'd1; reg_wdata = 32'h0041; end
              default: begin reg_sel = 4'd0; reg_wdata = 32'h0; end
            endcase
          end
          forever begin
            gnt = ($urandom_range(0, 99) < gp);
            ok = busy && req && (ch == 2'(k)) && (addr == ep[k]) && (we == (k == 3)) &&
                 (first == (c == 0)) && (last == (c == w - 1));
            if (!ok) begin
              // R4 order, R5/R6 addresses, R8 stall hold, R9 row flags
              chk(0, desc ? "R6/R4/R8/R9 access" : "R5/R4/R8/R9 access",
                  {req, we, first, last, 2'(ch), addr},
                  {1'b1, 1'(k == 3), 1'(c == 0), 1'(c == w - 1), 2'(k), ep[k]});
              gnt = 0; reg_we = 0;
              return;
            end
            cyc++;
            if (gnt) break;
            tries++;
            if (tries > 1000) begin
              chk(0, "R8 grant wait", tries, 1000);
              gnt = 0; reg_we = 0;
              return;
            end
            @(negedge clk);
          end
          if (k < 3) sv[k] = rdata;
          else if (wdata != exp_w(en, sv[0], sv[1], sv[2])) begin
            chk(0, "R11 write data", wdata, exp_w(en, sv[0], sv[1], sv[2]));
            gnt = 0; reg_we = 0;
            return;
          end
          stp = (c == w - 1) ? AW'(2) + {{(AW-16){em[k][15]}}, em[k]} : AW'(2);
          ep[k] = desc ? ep[k] - stp : ep[k] + stp;
          nacc++;
          @(negedge clk);
        end
    gnt = 0; reg_we = 0;
    chk(nacc == w * h * $countones(en), "R1/R3 access count", nacc, w * h * $countones(en));
    chk(!busy && !req, "R2 busy clear at end", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int cyc;
    logic [3:0] en;
    process::self().srandom(32'h5eed_0042);
    gnt = 0;
    for (int i = 0; i < 4; i++) begin ep[i] = '0; em[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!busy && !req, "R2 reset state", {busy, req}, 0);
    rst_n = 1'b1;

    // R12: start with nothing enabled
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h0043);
    chk(!busy && !req, "R12 empty start", busy, 0);
    @(negedge clk);
    chk(!busy, "R12 still idle", busy, 0);

    // R1 zero width -> 64 words, R3 cycle count
    set_ptr(3, 20'h01000); set_mod(3, 16'h0004);
    gp = 100;
    run(4'b1000, 0, {10'd2, 6'd0}, 0, cyc);
    chk(cyc == 128, "R1/R3 zero width cycles", cyc, 128);

    // R1 zero height -> 1024 rows
    set_ptr(3, 20'h20000); set_mod(3, 16'hFFFE);
    run(4'b1000, 0, {10'd0, 6'd1}, 0, cyc);
    chk(cyc == 1024, "R1 zero height cycles", cyc, 1024);

    // R3/R4/R11 all four channels, grant 100% for cycle count
    for (int i = 0; i < 4; i++) begin
      set_ptr(i, AW'(32'h400 * (i + 1))); set_mod(i, 16'(2 * i - 2));
    end
    run(4'b1111, 0, {10'd2, 6'd3}, 0, cyc);
    chk(cyc == 24, "R3 four channel cycles", cyc, 24);

    // R6 descending with stalls
    gp = 60;
    set_ptr(0, 20'h08FFE); set_mod(0, 16'd6);
    set_ptr(3, 20'h09FFE); set_mod(3, 16'hFFF8);
    run(4'b1001, 1, {10'd3, 6'd4}, 0, cyc);

    // R7 continue from advanced pointers without rewriting them
    run(4'b1001, 1, {10'd2, 6'd2}, 0, cyc);

    // R10 writes during a walk are ignored; B+C only -> R11 picks B
    set_ptr(1, 20'h0C000); set_mod(1, 16'd10);
    set_ptr(2, 20'h0D000); set_mod(2, 16'hFFF0);
    set_ptr(0, 20'h0E000);
    run(4'b0110, 0, {10'd2, 6'd3}, 1, cyc);
    run(4'b0110, 0, {10'd1, 6'd2}, 0, cyc);  // R10/R7: pointers untouched by mid-walk writes

    // Random walks
    for (int t = 0; t < 25; t++) begin
      en = 4'($urandom_range(1, 15));
      gp = $urandom_range(40, 100);
      if (t % 4 == 0)
        for (int i = 0; i < 4; i++) begin
          set_ptr(i, AW'($urandom) & ~AW'(1));
          set_mod(i, 16'($urandom_range(0, 40)) - 16'd20 & 16'hFFFE);
        end
      run(en, 1'($urandom_range(0, 1)),
          {10'($urandom_range(1, 4)), 6'($urandom_range(1, 5))}, 0, cyc);
    end
    summary();
  end
endmodule